// File: doc/BRIEF.md
# Pipeline Forwarding and Hazard Control

This block is the operand-steering and interlock logic for an in-order pipeline with five stages, run in the order fetch, decode, execute, memory access, write-back. It has no datapath of its own. Each cycle it looks at the register indices, write enables and load flags held in the pipeline registers. From them it picks where each execute-stage operand comes from: the register file, the result held after execute, or the result held after memory access. It also tells fetch and decode to hold, and puts a bubble into execute, whenever no bypass can deliver a value in time.

The register file is written in the first half of the write-back cycle and read in the second half of the decode cycle. A producer in write-back therefore never needs a bypass toward decode. Branches are decided in decode and have a single delay slot: the instruction fetched right after a branch always runs. For that reason the block never flushes anything. It only requests a redirect of the fetch address when a branch in decode is taken and its operands are ready. A branch comparator in decode can take a value from the memory-stage result through its own one-bit selects. A branch that depends on an instruction still in execute, or on a load still in memory access, must wait.

All outputs are combinational functions of the current pipeline-register fields. The clock and reset feed only the embedded assertions.

Top module: `fwd_hazard_unit`

## Requirements
- R1: An execute operand whose source index equals the destination of a register-writing instruction in the memory stage gets select 2'b10. The encoding 2'b11 is never produced.
- R2: If only the write-back-stage instruction writes that source register, the select is 2'b01.
- R3: When both the memory-stage and the write-back-stage producers match the same source, the select is 2'b10.
- R4: A producer whose destination is index 0, or whose write enable is low, never causes a bypass for that producer.
- R5: With no matching producer the select is 2'b00. A decode source that matches only the write-back destination causes no stall and no branch bypass.
- R6: A load in execute whose non-zero destination equals a decode source that is in use raises hold_pc, hold_ifid and bubble_idex together. A source marked unused never triggers this.
- R7: A load in execute with destination 0 causes no stall.
- R8: A branch in decode stalls when a register-writing instruction in execute targets one of its used sources. A non-branch with the same dependence does not stall.
- R9: A branch in decode stalls on a load in the memory stage that targets its source. A non-load producer in the memory stage is instead bypassed to the comparator (br_fwd_a or br_fwd_b = 1) without a stall.
- R10: branch_redirect is high only when a branch in decode has a true condition and no stall is raised. The delay-slot instruction is never squashed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the assertions |
| rst_n | input | 1 | Active-low reset for the assertions |
| id_rs | input | 5 | First source index of the instruction in decode |
| id_rt | input | 5 | Second source index of the instruction in decode |
| id_uses_rs | input | 1 | Decode instruction reads its first source |
| id_uses_rt | input | 1 | Decode instruction reads its second source |
| id_is_branch | input | 1 | Decode instruction is a conditional branch |
| id_br_cond | input | 1 | Branch comparator outcome in decode |
| ex_rs | input | 5 | First source index held in ID/EX |
| ex_rt | input | 5 | Second source index held in ID/EX |
| ex_rd | input | 5 | Destination index held in ID/EX |
| ex_regwrite | input | 1 | ID/EX instruction writes a register |
| ex_memread | input | 1 | ID/EX instruction is a load |
| mem_rd | input | 5 | Destination index held in EX/MEM |
| mem_regwrite | input | 1 | EX/MEM instruction writes a register |
| mem_memread | input | 1 | EX/MEM instruction is a load |
| wb_rd | input | 5 | Destination index held in MEM/WB |
| wb_regwrite | input | 1 | MEM/WB instruction writes a register |
| fwd_a | output | 2 | First operand select: 00 file, 10 EX/MEM, 01 MEM/WB |
| fwd_b | output | 2 | Second operand select, same encoding |
| br_fwd_a | output | 1 | Branch comparator first operand from EX/MEM |
| br_fwd_b | output | 1 | Branch comparator second operand from EX/MEM |
| hold_pc | output | 1 | Keep the program counter |
| hold_ifid | output | 1 | Keep the IF/ID register |
| bubble_idex | output | 1 | Clear the control bits entering ID/EX |
| branch_redirect | output | 1 | Load the branch target into the program counter |

## Verification
Two things can happen in the same cycle: a taken branch sits in decode while a hazard raises the stall. The bench drives a branch with a true condition while it depends on an ALU result in execute, and again while it depends on a load in memory access. It expects the stall outputs high and branch_redirect low. It then moves the same producer to the memory stage as a non-load, or to write-back, and expects the redirect with no stall. A second overlap is a hit in both bypass levels on one source, which is judged by the select encoding.

// File: rtl/fh_pkg.sv
package fh_pkg;
  localparam int IDX_W = 5;

  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_WB  = 2'b01,
    FWD_MEM = 2'b10
  } fwd_sel_e;

  // A producer supplies a source when it writes a non-zero register equal to it
  function automatic logic prod_hit(input logic we,
                                    input logic [IDX_W-1:0] dst,
                                    input logic [IDX_W-1:0] src);
    return we && (dst != '0) && (dst == src);
  endfunction
endpackage

// File: rtl/fh_bypass.sv
module fh_bypass
  import fh_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] src,
  input  logic [IDX_W-1:0] mem_rd,
  input  logic             mem_we,
  input  logic [IDX_W-1:0] wb_rd,
  input  logic             wb_we,
  output logic [1:0]       sel
);
  logic hit_mem, hit_wb;
  assign hit_mem = prod_hit(mem_we, mem_rd, src);
  assign hit_wb  = prod_hit(wb_we, wb_rd, src);

  always_comb begin
    if (hit_mem)     sel = FWD_MEM;
    else if (hit_wb) sel = FWD_WB;
    else             sel = FWD_RF;
  end

  AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    sel != 2'b11); // R1
  AST_ZERO_NEVER_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    (src == '0) |-> (sel == 2'b00)); // R4
  AST_MEM_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && wb_we && mem_rd == src && wb_rd == src && src != '0) |-> (sel == 2'b10)); // R3
endmodule

// File: rtl/fh_stall.sv
module fh_stall
  import fh_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] id_rs,
  input  logic [IDX_W-1:0] id_rt,
  input  logic             id_uses_rs,
  input  logic             id_uses_rt,
  input  logic             id_is_branch,
  input  logic [IDX_W-1:0] ex_rd,
  input  logic             ex_regwrite,
  input  logic             ex_memread,
  input  logic [IDX_W-1:0] mem_rd,
  input  logic             mem_regwrite,
  input  logic             mem_memread,
  output logic             load_use,
  output logic             branch_wait,
  output logic             stall
);
  logic ex_ld_rs, ex_ld_rt, ex_wr_rs, ex_wr_rt, mem_ld_rs, mem_ld_rt;

  assign ex_ld_rs  = id_uses_rs && prod_hit(ex_memread, ex_rd, id_rs);
  assign ex_ld_rt  = id_uses_rt && prod_hit(ex_memread, ex_rd, id_rt);
  assign ex_wr_rs  = id_uses_rs && prod_hit(ex_regwrite, ex_rd, id_rs);
  assign ex_wr_rt  = id_uses_rt && prod_hit(ex_regwrite, ex_rd, id_rt);
  assign mem_ld_rs = id_uses_rs && prod_hit(mem_memread && mem_regwrite, mem_rd, id_rs);
  assign mem_ld_rt = id_uses_rt && prod_hit(mem_memread && mem_regwrite, mem_rd, id_rt);

  assign load_use    = ex_ld_rs || ex_ld_rt;
  assign branch_wait = id_is_branch && (ex_wr_rs || ex_wr_rt || mem_ld_rs || mem_ld_rt);
  assign stall       = load_use || branch_wait;

  AST_LOAD_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_memread && ex_rd != '0 && id_uses_rs && ex_rd == id_rs) |-> stall); // R6
  AST_ZERO_LOAD_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (!id_is_branch && ex_rd == '0) |-> !stall); // R7
endmodule

// File: rtl/fh_branch.sv
module fh_branch
  import fh_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] id_rs,
  input  logic [IDX_W-1:0] id_rt,
  input  logic             id_is_branch,
  input  logic             id_br_cond,
  input  logic [IDX_W-1:0] mem_rd,
  input  logic             mem_regwrite,
  input  logic             mem_memread,
  input  logic             stall,
  output logic             br_fwd_a,
  output logic             br_fwd_b,
  output logic             redirect
);
  logic alu_in_mem;
  assign alu_in_mem = mem_regwrite && !mem_memread;

  assign br_fwd_a = prod_hit(alu_in_mem, mem_rd, id_rs);
  assign br_fwd_b = prod_hit(alu_in_mem, mem_rd, id_rt);
  assign redirect = id_is_branch && id_br_cond && !stall;

  AST_NO_REDIRECT_IN_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !redirect); // R10
  AST_LOAD_NOT_BYPASSED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_memread |-> !(br_fwd_a || br_fwd_b)); // R9
endmodule

// File: rtl/fwd_hazard_unit.sv
module fwd_hazard_unit
  import fh_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] id_rs,
  input  logic [IDX_W-1:0] id_rt,
  input  logic             id_uses_rs,
  input  logic             id_uses_rt,
  input  logic             id_is_branch,
  input  logic             id_br_cond,
  input  logic [IDX_W-1:0] ex_rs,
  input  logic [IDX_W-1:0] ex_rt,
  input  logic [IDX_W-1:0] ex_rd,
  input  logic             ex_regwrite,
  input  logic             ex_memread,
  input  logic [IDX_W-1:0] mem_rd,
  input  logic             mem_regwrite,
  input  logic             mem_memread,
  input  logic [IDX_W-1:0] wb_rd,
  input  logic             wb_regwrite,
  output logic [1:0]       fwd_a,
  output logic [1:0]       fwd_b,
  output logic             br_fwd_a,
  output logic             br_fwd_b,
  output logic             hold_pc,
  output logic             hold_ifid,
  output logic             bubble_idex,
  output logic             branch_redirect
);
  localparam int NUM_OPS = 2;

  logic [IDX_W-1:0] op_src [NUM_OPS];
  logic [1:0]       op_sel [NUM_OPS];
  logic load_use, branch_wait, stall;

  assign op_src[0] = ex_rs;
  assign op_src[1] = ex_rt;

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    fh_bypass u_byp (
      .clk(clk), .rst_n(rst_n), .src(op_src[g]),
      .mem_rd(mem_rd), .mem_we(mem_regwrite),
      .wb_rd(wb_rd), .wb_we(wb_regwrite),
      .sel(op_sel[g])
    );
  end

  assign fwd_a = op_sel[0];
  assign fwd_b = op_sel[1];

  fh_stall u_stall (
    .clk(clk), .rst_n(rst_n),
    .id_rs(id_rs), .id_rt(id_rt),
    .id_uses_rs(id_uses_rs), .id_uses_rt(id_uses_rt),
    .id_is_branch(id_is_branch),
    .ex_rd(ex_rd), .ex_regwrite(ex_regwrite), .ex_memread(ex_memread),
    .mem_rd(mem_rd), .mem_regwrite(mem_regwrite), .mem_memread(mem_memread),
    .load_use(load_use), .branch_wait(branch_wait), .stall(stall)
  );

  fh_branch u_br (
    .clk(clk), .rst_n(rst_n),
    .id_rs(id_rs), .id_rt(id_rt),
    .id_is_branch(id_is_branch), .id_br_cond(id_br_cond),
    .mem_rd(mem_rd), .mem_regwrite(mem_regwrite), .mem_memread(mem_memread),
    .stall(stall),
    .br_fwd_a(br_fwd_a), .br_fwd_b(br_fwd_b), .redirect(branch_redirect)
  );

  assign hold_pc     = stall;
  assign hold_ifid   = stall;
  assign bubble_idex = stall;

  AST_WB_NEEDS_NOTHING: assert property (@(posedge clk) disable iff (!rst_n)
    (!ex_regwrite && !mem_regwrite) |-> !(hold_pc || br_fwd_a || br_fwd_b)); // R5
  AST_PLAIN_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!id_is_branch && !ex_memread) |-> !bubble_idex); // R8
  AST_LOAD_WAIT_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    load_use |-> (hold_ifid && !branch_redirect)); // R6
  AST_BRANCH_WAIT_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    branch_wait |-> !branch_redirect); // R10
endmodule

// File: tb/fwd_hazard_unit_test.sv
module fwd_hazard_unit_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [4:0] id_rs, id_rt, ex_rs, ex_rt, ex_rd, mem_rd, wb_rd;
  logic id_uses_rs, id_uses_rt, id_is_branch, id_br_cond;
  logic ex_regwrite, ex_memread, mem_regwrite, mem_memread, wb_regwrite;
  logic [1:0] fwd_a, fwd_b;
  logic br_fwd_a, br_fwd_b, hold_pc, hold_ifid, bubble_idex, branch_redirect;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  fwd_hazard_unit uut (.*);

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    {id_rs, id_rt, ex_rs, ex_rt, ex_rd, mem_rd, wb_rd} = '0;
    {id_uses_rs, id_uses_rt, id_is_branch, id_br_cond} = '0;
    {ex_regwrite, ex_memread, mem_regwrite, mem_memread, wb_regwrite} = '0;
  endtask

  task automatic settle(); #1; endtask

  task automatic chk_stall(input string req, input logic exp);
    chk({req, " hold_pc"}, hold_pc, exp);
    chk({req, " hold_ifid"}, hold_ifid, exp);
    chk({req, " bubble"}, bubble_idex, exp);
  endtask

  task automatic t_reset_state();
    idle(); settle();
    chk("R5 idle fwd_a", fwd_a, 0);
    chk("R5 idle fwd_b", fwd_b, 0);
    chk_stall("R5 idle", 1'b0);
    chk("R10 idle redirect", branch_redirect, 0);
  endtask

  task automatic t_mem_forward();
    idle(); ex_rs = 3; ex_rt = 4; mem_rd = 3; mem_regwrite = 1; settle();
    chk("R1 mem fwd_a", fwd_a, 2);
    chk("R5 other fwd_b", fwd_b, 0);
  endtask

  task automatic t_wb_forward();
    idle(); ex_rs = 6; ex_rt = 7; wb_rd = 7; wb_regwrite = 1; settle();
    chk("R2 wb fwd_b", fwd_b, 1);
    chk("R5 other fwd_a", fwd_a, 0);
  endtask

  task automatic t_priority();
    idle(); ex_rs = 5; ex_rt = 5; mem_rd = 5; wb_rd = 5;
    mem_regwrite = 1; wb_regwrite = 1; settle();
    chk("R3 both fwd_a", fwd_a, 2);
    chk("R3 both fwd_b", fwd_b, 2);
  endtask

  task automatic t_zero_and_nowrite();
    idle(); ex_rs = 0; mem_rd = 0; mem_regwrite = 1; wb_rd = 0; wb_regwrite = 1; settle();
    chk("R4 zero dest", fwd_a, 0);
    idle(); ex_rs = 9; mem_rd = 9; mem_regwrite = 0; settle();
    chk("R4 no write", fwd_a, 0);
    wb_rd = 9; wb_regwrite = 1; settle();
    chk("R4 falls to wb", fwd_a, 1);
  endtask

  task automatic t_load_use();
    idle(); ex_memread = 1; ex_regwrite = 1; ex_rd = 8;
    id_rs = 8; id_uses_rs = 1; settle();
    chk_stall("R6 rs load", 1'b1);
    id_uses_rs = 0; settle();
    chk_stall("R6 unused rs", 1'b0);
    id_rs = 0; id_rt = 8; id_uses_rt = 1; settle();
    chk_stall("R6 rt load", 1'b1);
    ex_regwrite = 0; ex_memread = 0; settle();
    chk_stall("R8 alu in ex nonbranch", 1'b0);
  endtask

  task automatic t_zero_load();
    idle(); ex_memread = 1; ex_regwrite = 1; ex_rd = 0;
    id_rs = 0; id_uses_rs = 1; settle();
    chk_stall("R7 zero load", 1'b0);
  endtask

  task automatic t_branch_wb_only();
    idle(); id_is_branch = 1; id_br_cond = 1; id_rs = 9; id_uses_rs = 1;
    wb_rd = 9; wb_regwrite = 1; settle();
    chk_stall("R5 wb only", 1'b0);
    chk("R5 no br fwd", br_fwd_a, 0);
    chk("R10 taken redirect", branch_redirect, 1);
    id_br_cond = 0; settle();
    chk("R10 not taken", branch_redirect, 0);
  endtask

  task automatic t_branch_vs_stall();
    idle(); id_is_branch = 1; id_br_cond = 1; id_rt = 10; id_uses_rt = 1;
    ex_rd = 10; ex_regwrite = 1; settle();
    chk_stall("R8 branch on ex alu", 1'b1);
    chk("R10 redirect held", branch_redirect, 0);
    idle(); id_is_branch = 1; id_br_cond = 1; id_rs = 11; id_uses_rs = 1;
    mem_rd = 11; mem_regwrite = 1; mem_memread = 1; settle();
    chk_stall("R9 branch on mem load", 1'b1);
    chk("R9 no load bypass", br_fwd_a, 0);
    chk("R10 redirect held", branch_redirect, 0);
    mem_memread = 0; settle();
    chk_stall("R9 alu in mem", 1'b0);
    chk("R9 br_fwd_a", br_fwd_a, 1);
    chk("R9 br_fwd_b", br_fwd_b, 0);
    chk("R10 redirect", branch_redirect, 1);
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_mem_forward();
    t_wb_forward();
    t_priority();
    t_zero_and_nowrite();
    t_load_use();
    t_zero_load();
    t_branch_wb_only();
    t_branch_vs_stall();
    idle();
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule